// File: doc/BRIEF.md
# Programmed-IO Ethernet Frame Buffer

This block sits between a host CPU and an Ethernet MAC on a chip with no DMA engine for the management port. The host moves whole frames through a small 32-bit register window. To send, it writes the frame into a transmit word port one 32-bit word at a time, then writes the byte count with the start bit set. The block then streams the bytes to the MAC and reports completion. To receive, the block collects one frame from the MAC into a local buffer and raises a ready flag. The host reads the frame out word by word and then acknowledges it, which lets the MAC deliver the next frame.

Each direction holds exactly one frame at a time. One interrupt line carries two causes. The first is a level that stays high while a received frame waits. The second is a single-cycle pulse when a transmission completes. Each cause has its own enable bit. Frame bytes sit big-endian in every word. Byte lengths are 11 bits wide. The buffer depth in words is a parameter.

Top module: `pio_eth_fbuf`

## Requirements
- R1: After reset, transmit control (offset 0x800) and receive control (offset 0x810) read zero, `irq` is low, `tx_valid` is low and `rx_ready` is high.
- R2: After the host writes ceil(len/4) words to transmit data (0x808) and launches, the MAC sees exactly len bytes, first frame byte taken from word bits 31:24, then 23:16, 15:8, 7:0; `tx_last` marks the final byte; `tx_data`/`tx_last` hold while `tx_ready` is low; tail bytes of the last word are not sent.
- R3: Transmit control reads {busy bit 15, fail bit 14, length bits 10:0}; a write with bit 15 set starts a frame of length bits 10:0, busy reads 1 until the final byte is accepted and 0 afterwards, with bit 14 equal to `tx_fail` at the final byte and the length kept.
- R4: A write to transmit control while busy is set has no effect on the running frame or its length.
- R5: A write to transmit control with bit 15 clear while idle clears length and fail, and discards words already written, so the next frame starts from its first word.
- R6: After a frame's final byte (`rx_last`) the receive control reads {ready bit 15, error bit 14 = `rx_bad`, CRC error bit 13 = `rx_crc_bad`, length bits 10:0}, and `rx_ready` stays low while ready is set.
- R7: Each read of receive data (0x818) while ready returns the next word, big-endian, with bytes past the frame length reading zero; reads past the frame's last word return zero.
- R8: A read of receive data while ready is clear returns zero and does not advance the read position.
- R9: Any write to receive control while ready is set clears the status and accepts the next frame from the MAC.
- R10: `irq` is high while a received frame is ready and enable bit 0 (offset 0x8C0) is set, and low from it when the bit is clear.
- R11: The transmit completion drives `irq` for exactly the one cycle after the final byte's handshake, only when enable bit 1 is set.
- R12: Receive bytes beyond the buffer capacity (4 x DEPTH_WORDS) are dropped while the reported length still counts them; their word reads return zero.
- R13: A launch with length zero sends no bytes and completes on the next cycle with the fail bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data) |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the strobe cycle |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | MAC accepts transmit byte |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_fail | input | 1 | MAC reports failed send, sampled at the final byte |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Block accepts receive byte |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Final received byte |
| rx_crc_bad | input | 1 | CRC error status, with the final byte |
| rx_bad | input | 1 | Receive error status, with the final byte |
| irq | output | 1 | Interrupt |

## Verification
The bench builds the block with DEPTH_WORDS = 8, so the buffer holds 32 bytes. At this depth a transmit frame that fills the buffer exactly is a short vector. A receive frame of 40 bytes then overruns the buffer, which exercises the dropped-byte and zero-readback path of R12 in a few hundred cycles. The 11-bit length field is unaffected by the depth, so the status encodings are the same as at the default size.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

    localparam int LEN_W  = 11;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_TXCTL = 12'h800;
    localparam logic [ADDR_W-1:0] OFS_TXDAT = 12'h808;
    localparam logic [ADDR_W-1:0] OFS_RXCTL = 12'h810;
    localparam logic [ADDR_W-1:0] OFS_RXDAT = 12'h818;
    localparam logic [ADDR_W-1:0] OFS_IEN   = 12'h8C0;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_TXCTL, SEL_TXDAT, SEL_RXCTL, SEL_RXDAT, SEL_IEN
    } reg_sel_e;

    typedef struct packed {
        logic             busy;
        logic             fail;
        logic [LEN_W-1:0] len;
    } tx_stat_t;

    typedef struct packed {
        logic             rdy;
        logic             bad;
        logic             crc;
        logic [LEN_W-1:0] len;
    } rx_stat_t;

    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_TXCTL: return SEL_TXCTL;
            OFS_TXDAT: return SEL_TXDAT;
            OFS_RXCTL: return SEL_RXCTL;
            OFS_RXDAT: return SEL_RXDAT;
            OFS_IEN:   return SEL_IEN;
            default:   return SEL_NONE;
        endcase
    endfunction

    // big-endian lane: lane 0 is bits 31:24
    function automatic logic [7:0] lane_byte(input logic [31:0] w, input logic [1:0] lane);
        return w[8*(3-int'(lane)) +: 8];
    endfunction

    function automatic logic [LEN_W-1:0] words_of(input logic [LEN_W-1:0] n);
        logic [LEN_W:0] t;
        t = {1'b0, n} + (LEN_W+1)'(3);
        return {1'b0, t[LEN_W:2]};
    endfunction

    function automatic logic [31:0] tx_word(input tx_stat_t s);
        return {16'h0, s.busy, s.fail, 3'b000, s.len};
    endfunction

    function automatic logic [31:0] rx_word(input rx_stat_t s);
        return {16'h0, s.rdy, s.bad, s.crc, 2'b00, s.len};
    endfunction

endpackage

// File: rtl/pfb_tx.sv
module pfb_tx
    import pfb_pkg::*;
#(
    parameter int DEPTH_WORDS = 512
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        push,
    input  logic [31:0] push_data,
    input  logic        ctl_wr,
    input  logic [31:0] ctl_wdata,
    output tx_stat_t    stat,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    input  logic        tx_fail,
    output logic        done_evt
);
    localparam int AW = (DEPTH_WORDS > 1) ? $clog2(DEPTH_WORDS) : 1;
    localparam logic [LEN_W-1:0] CAP = LEN_W'(DEPTH_WORDS);

    logic [31:0]      mem [DEPTH_WORDS];
    logic [LEN_W-1:0] wptr;
    logic [LEN_W-1:0] bidx;
    logic [LEN_W-1:0] widx;
    logic [31:0]      cur_word;
    logic             beat;
    logic             finish;
    tx_stat_t         st;

    assign stat     = st;
    assign widx     = {2'b00, bidx[LEN_W-1:2]};
    assign cur_word = (widx < CAP) ? mem[widx[AW-1:0]] : 32'h0;
    assign tx_valid = st.busy && (st.len != '0);
    assign tx_data  = lane_byte(cur_word, bidx[1:0]);
    assign tx_last  = tx_valid && (bidx == st.len - LEN_W'(1));
    assign beat     = tx_valid && tx_ready;
    assign finish   = st.busy && ((st.len == '0) || (beat && tx_last));
    assign done_evt = finish;

    always_ff @(posedge clk) begin
        if (push && !st.busy && (wptr < CAP))
            mem[wptr[AW-1:0]] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            bidx <= '0;
            st   <= '0;
        end else begin
            if (push && !st.busy && (wptr != '1))
                wptr <= wptr + LEN_W'(1);
            if (ctl_wr && !st.busy) begin
                bidx <= '0;
                if (ctl_wdata[15]) begin
                    st.busy <= 1'b1;
                    st.fail <= 1'b0;
                    st.len  <= ctl_wdata[LEN_W-1:0];
                end else begin
                    st   <= '0;
                    wptr <= '0;
                end
            end
            if (beat)
                bidx <= bidx + LEN_W'(1);
            if (finish) begin
                st.busy <= 1'b0;
                st.fail <= (st.len != '0) && tx_fail;
                wptr    <= '0;
            end
        end
    end

    p_stream_hold_r2: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

    p_busy_ignore_r4: assert property (@(posedge clk) disable iff (rst)
        st.busy && ctl_wr && !finish |=> st.busy && $stable(st.len));

    p_done_clears_r3: assert property (@(posedge clk) disable iff (rst)
        finish |=> !st.busy);

endmodule

// File: rtl/pfb_rx.sv
module pfb_rx
    import pfb_pkg::*;
#(
    parameter int DEPTH_WORDS = 512
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_valid,
    output logic        rx_ready,
    input  logic [7:0]  rx_data,
    input  logic        rx_last,
    input  logic        rx_crc_bad,
    input  logic        rx_bad,
    input  logic        pop,
    input  logic        ack,
    output rx_stat_t    stat,
    output logic [31:0] pop_word
);
    localparam int AW = (DEPTH_WORDS > 1) ? $clog2(DEPTH_WORDS) : 1;
    localparam logic [LEN_W-1:0] CAP = LEN_W'(DEPTH_WORDS);

    logic [31:0]      mem [DEPTH_WORDS];
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] rptr;
    logic [LEN_W-1:0] widx;
    logic [1:0]       lane;
    logic [LEN_W-1:0] nwords;
    logic [LEN_W-1:0] avail;
    logic             take;
    rx_stat_t         st;

    assign stat     = st;
    assign rx_ready = !st.rdy;
    assign take     = rx_valid && !st.rdy;
    assign widx     = {2'b00, cnt[LEN_W-1:2]};
    assign lane     = cnt[1:0];
    assign nwords   = words_of(st.len);
    assign avail    = (nwords < CAP) ? nwords : CAP;
    assign pop_word = (st.rdy && (rptr < avail)) ? mem[rptr[AW-1:0]] : 32'h0;

    always_ff @(posedge clk) begin
        if (take && (widx < CAP)) begin
            if (lane == 2'd0)
                mem[widx[AW-1:0]] <= {rx_data, 24'h0};
            else
                mem[widx[AW-1:0]][8*(3-int'(lane)) +: 8] <= rx_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            rptr <= '0;
            st   <= '0;
        end else begin
            if (take) begin
                if (cnt != '1)
                    cnt <= cnt + LEN_W'(1);
                if (rx_last) begin
                    st.rdy <= 1'b1;
                    st.len <= (cnt == '1) ? cnt : cnt + LEN_W'(1);
                    st.crc <= rx_crc_bad;
                    st.bad <= rx_bad;
                    cnt    <= '0;
                end
            end
            if (pop && st.rdy && (rptr != '1))
                rptr <= rptr + LEN_W'(1);
            if (ack && st.rdy) begin
                st   <= '0;
                rptr <= '0;
            end
        end
    end

    p_rdy_hold_r6: assert property (@(posedge clk) disable iff (rst)
        st.rdy && !ack |=> st.rdy && $stable(st.len));

    p_idle_pop_r8: assert property (@(posedge clk) disable iff (rst)
        !st.rdy && pop |=> rptr == $past(rptr));

endmodule

// File: rtl/pfb_irq.sv
module pfb_irq (
    input  logic       clk,
    input  logic       rst,
    input  logic       ien_wr,
    input  logic [1:0] ien_wdata,
    input  logic       done_evt,
    input  logic       rx_rdy,
    output logic [1:0] ien,
    output logic       irq
);
    logic done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ien    <= 2'b00;
            done_q <= 1'b0;
        end else begin
            if (ien_wr)
                ien <= ien_wdata;
            done_q <= done_evt;
        end
    end

    assign irq = (rx_rdy && ien[0]) || (done_q && ien[1]);

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

endmodule

// File: rtl/pio_eth_fbuf.sv
module pio_eth_fbuf
    import pfb_pkg::*;
#(
    parameter int DEPTH_WORDS = 512
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [11:0] reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    input  logic        tx_fail,
    input  logic        rx_valid,
    output logic        rx_ready,
    input  logic [7:0]  rx_data,
    input  logic        rx_last,
    input  logic        rx_crc_bad,
    input  logic        rx_bad,
    output logic        irq
);
    reg_sel_e    sel;
    tx_stat_t    tx_st;
    rx_stat_t    rx_st;
    logic [31:0] rx_pop_word;
    logic [1:0]  ien_q;
    logic        done_evt;

    assign sel = decode_ofs(reg_addr);

    pfb_tx #(.DEPTH_WORDS(DEPTH_WORDS)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .push      (reg_wr && (sel == SEL_TXDAT)),
        .push_data (reg_wdata),
        .ctl_wr    (reg_wr && (sel == SEL_TXCTL)),
        .ctl_wdata (reg_wdata),
        .stat      (tx_st),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .tx_data   (tx_data),
        .tx_last   (tx_last),
        .tx_fail   (tx_fail),
        .done_evt  (done_evt)
    );

    pfb_rx #(.DEPTH_WORDS(DEPTH_WORDS)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .rx_valid   (rx_valid),
        .rx_ready   (rx_ready),
        .rx_data    (rx_data),
        .rx_last    (rx_last),
        .rx_crc_bad (rx_crc_bad),
        .rx_bad     (rx_bad),
        .pop        (reg_rd && (sel == SEL_RXDAT)),
        .ack        (reg_wr && (sel == SEL_RXCTL)),
        .stat       (rx_st),
        .pop_word   (rx_pop_word)
    );

    pfb_irq u_irq (
        .clk       (clk),
        .rst       (rst),
        .ien_wr    (reg_wr && (sel == SEL_IEN)),
        .ien_wdata (reg_wdata[1:0]),
        .done_evt  (done_evt),
        .rx_rdy    (rx_st.rdy),
        .ien       (ien_q),
        .irq       (irq)
    );

    always_comb begin
        case (sel)
            SEL_TXCTL: reg_rdata = tx_word(tx_st);
            SEL_RXCTL: reg_rdata = rx_word(rx_st);
            SEL_RXDAT: reg_rdata = rx_pop_word;
            SEL_IEN:   reg_rdata = {30'h0, ien_q};
            default:   reg_rdata = 32'h0;
        endcase
    end

    p_irq_rx_r10: assert property (@(posedge clk) disable iff (rst)
        rx_st.rdy && ien_q[0] |-> irq);

    p_idle_stream_r1: assert property (@(posedge clk) disable iff (rst)
        !tx_st.busy |-> !tx_valid);

endmodule

// File: tb/tb_pio_eth_fbuf.sv
module tb_pio_eth_fbuf;
    localparam int DW = 8;
    localparam logic [11:0] A_TXC = 12'h800, A_TXD = 12'h808, A_RXC = 12'h810,
                            A_RXD = 12'h818, A_IEN = 12'h8C0;
    localparam int NV = 7;
    localparam int  VEC_LEN  [NV] = '{1, 4, 5, 7, 8, 13, 32};
    localparam bit  VEC_FAIL [NV] = '{0, 0, 1, 0, 0, 1, 0};
    localparam bit  VEC_IEN  [NV] = '{1, 0, 1, 1, 0, 1, 1};

    logic clk = 0;
    logic rst = 1;
    logic reg_wr = 0, reg_rd = 0;
    logic [11:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic tx_valid, tx_last, rx_ready, irq;
    logic [7:0] tx_data;
    logic tx_ready = 0, tx_fail = 0;
    logic rx_valid = 0, rx_last = 0, rx_crc_bad = 0, rx_bad = 0;
    logic [7:0] rx_data = 0;

    int nchk = 0;
    int nfail = 0;
    bit ended = 0;

    always #5 clk = ~clk;

    pio_eth_fbuf #(.DEPTH_WORDS(DW)) dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last), .tx_fail(tx_fail),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_last(rx_last),
        .rx_crc_bad(rx_crc_bad), .rx_bad(rx_bad), .irq(irq)
    );

    function automatic logic [7:0] txb(int f, int i);
        return 8'(f * 37 + i * 5 + 1);
    endfunction

    function automatic logic [7:0] rxb(int s, int i);
        return 8'(s * 11 + i * 3 + 7);
    endfunction

    function automatic logic [31:0] rx_exp(int s, int k, int n);
        logic [31:0] w;
        w = 0;
        for (int j = 0; j < 4; j++) begin
            int idx;
            idx = 4 * k + j;
            if (idx < n && idx < 4 * DW)
                w[8*(3-j) +: 8] = rxb(s, idx);
        end
        return w;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    endtask

    task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic send_rx(input int n, input bit crc, input bit bad, input int s);
        int i;
        i = 0;
        while (i < n) begin
            @(negedge clk);
            rx_valid = 1; rx_data = rxb(s, i); rx_last = (i == n - 1);
            rx_crc_bad = crc && (i == n - 1); rx_bad = bad && (i == n - 1);
            #1;
            if (rx_ready) i++;
        end
        @(negedge clk);
        rx_valid = 0; rx_last = 0; rx_crc_bad = 0; rx_bad = 0;
    endtask

    task automatic check_rx(input int n, input bit crc, input bit bad, input int s, input bit en);
        logic [31:0] r;
        reg_read(A_RXC, r);
        chk("R6 rx status", r, 32'h8000 | (bad ? 32'h4000 : 0) | (crc ? 32'h2000 : 0) | 32'(n));
        chk("R6 rx_ready low while ready", 32'(rx_ready), 0);
        chk("R10 irq level", 32'(irq), 32'(en));
        for (int k = 0; k < (n + 3) / 4; k++) begin
            reg_read(A_RXD, r);
            chk((4 * k + 4 > 4 * DW) ? "R12 word past capacity" : "R7 rx word", r, rx_exp(s, k, n));
        end
        reg_read(A_RXD, r);
        chk("R7 read past frame", r, 0);
        reg_write(A_RXC, 0);
        reg_read(A_RXC, r);
        chk("R9 ack clears status", r, 0);
        chk("R9 rx_ready after ack", 32'(rx_ready), 1);
        chk("R10 irq low after ack", 32'(irq), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_up();
    end

    initial begin
        logic [31:0] r;
        logic [31:0] w;
        int n, got, cyc;
        bit done;

        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        #1;
        chk("R1 irq", 32'(irq), 0);
        chk("R1 tx_valid", 32'(tx_valid), 0);
        chk("R1 rx_ready", 32'(rx_ready), 1);
        reg_read(A_TXC, r); chk("R1 txctl", r, 0);
        reg_read(A_RXC, r); chk("R1 rxctl", r, 0);

        // vector table walk: R2 R3 R4 R11
        for (int v = 0; v < NV; v++) begin
            n = VEC_LEN[v];
            reg_write(A_IEN, {30'h0, VEC_IEN[v], 1'b0});
            for (int k = 0; k < (n + 3) / 4; k++) begin
                for (int j = 0; j < 4; j++)
                    w[8*(3-j) +: 8] = (4 * k + j < n) ? txb(v, 4 * k + j) : 8'hEE;
                reg_write(A_TXD, w);
            end
            tx_fail = VEC_FAIL[v];
            reg_write(A_TXC, 32'h8000 | 32'(n));
            reg_read(A_TXC, r);
            chk("R3 busy after launch", r, 32'h8000 | 32'(n));
            reg_write(A_TXC, 32'h8003);
            reg_read(A_TXC, r);
            chk("R4 write while busy ignored", r, 32'h8000 | 32'(n));
            got = 0; cyc = 0; done = 0;
            while (!done && cyc < 2000) begin
                @(negedge clk);
                tx_ready = (cyc % 3) != 1;
                #1;
                if (tx_valid && tx_ready) begin
                    chk("R2 tx byte", 32'(tx_data), 32'(txb(v, got)));
                    chk("R2 tx_last", 32'(tx_last), 32'(got == n - 1));
                    if (tx_last) done = 1;
                    got++;
                end
                cyc++;
            end
            chk("R2 byte count", 32'(got), 32'(n));
            @(negedge clk);
            tx_ready = 0;
            #1 chk("R11 done pulse", 32'(irq), 32'(VEC_IEN[v]));
            @(negedge clk);
            #1 chk("R11 pulse one cycle", 32'(irq), 0);
            chk("R2 no extra byte", 32'(tx_valid), 0);
            reg_read(A_TXC, r);
            chk("R3 completion status", r, (VEC_FAIL[v] ? 32'h4000 : 0) | 32'(n));
            reg_write(A_TXC, 0);
            reg_read(A_TXC, r);
            chk("R5 ack clears", r, 0);
        end

        // R5: ack discards pushed words
        reg_write(A_IEN, 0);
        tx_fail = 0;
        reg_write(A_TXD, 32'hDEADBEEF);
        reg_write(A_TXC, 0);
        reg_write(A_TXD, 32'h11223344);
        reg_write(A_TXC, 32'h8004);
        got = 0;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            tx_ready = 1;
            #1;
            if (tx_valid) begin
                chk("R5 starts at first word", 32'(tx_data), 32'(8'h11 + 8'(got * 8'h11)));
                got++;
            end
        end
        tx_ready = 0;
        chk("R5 byte count", 32'(got), 4);
        reg_write(A_TXC, 0);

        // R13 zero-length launch
        tx_fail = 1;
        reg_write(A_TXC, 32'h8000);
        got = 0;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            tx_ready = 1;
            #1 if (tx_valid) got++;
        end
        tx_ready = 0;
        tx_fail = 0;
        chk("R13 no bytes", 32'(got), 0);
        reg_read(A_TXC, r);
        chk("R13 completes clean", r, 0);

        // R8: idle read of rx data
        reg_read(A_RXD, r);
        chk("R8 idle read zero", r, 0);
        reg_read(A_RXD, r);
        chk("R8 second idle read zero", r, 0);

        // receive frames
        reg_write(A_IEN, 32'h1);
        send_rx(5, 1, 0, 1);
        check_rx(5, 1, 0, 1, 1);
        reg_write(A_IEN, 32'h0);
        send_rx(9, 0, 1, 2);
        check_rx(9, 0, 1, 2, 0);
        reg_write(A_IEN, 32'h1);
        send_rx(40, 0, 0, 3);
        check_rx(40, 0, 0, 3, 1);

        finish_up();
    end
endmodule